// File: doc/BRIEF.md
# Interleaved Operand Replay Feeder

This block sits on the edge of a systolic matrix-multiply array and supplies it with operand vectors. A memory-side loader writes operand vectors for the A side and the B side into banked storage. Once both sides hold a complete bank, the block replays the stored vectors in a nested order: the A vector changes every cycle and the B vector is held, so each stored vector is reused over several cycles. A matching partial-sum slot index goes with every vector pair, so each processing element knows which stored partial result to accumulate into.

A block consists of K slices along the common dimension. Each slice takes IA*IB cycles, where IA and IB are the runtime interleave factors of the two sides. The same slot order repeats in every slice, so a slot always accumulates onto its own earlier value. A whole block therefore takes IA*IB*K cycles. The first slice is flagged so that downstream logic starts from zero. The factors and the slice count are read at the moment a block starts. Each side has several banks, so the loader can fill one bank while another is being replayed.

Top module: `ilv_operand_feeder`

## Requirements
- R1: After reset, `out_valid`, `out_first` and `out_last` are 0, and both `a_fill_ready` and `b_fill_ready` are 1.
- R2: Each side writes accepted fill vectors into its current write bank at consecutive addresses starting at 0. For slice s, the A vector with index a is stored at address s*IA+a, and the B vector with index b is stored at address s*IB+b. A beat with the last flag set closes the bank, and only a closed bank can be replayed.
- R3: A block starts only when the A side and the B side each hold a closed bank. With only one side closed, `out_valid` stays 0.
- R4: Within a block the A index is the innermost loop, the B index is the middle loop and the slice is the outer loop. Each cycle `out_a` equals the stored A[s*IA+a] and `out_b` equals the stored B[s*IB+b].
- R5: `out_slot` equals b*IA+a. Within each slice it runs from 0 to IA*IB-1 in steps of one, and it restarts at 0 in every slice.
- R6: `out_first` is 1 exactly on the output cycles of slice 0 of a block.
- R7: A block produces IA*IB*K consecutive valid cycles. `out_last` is 1 only on the final one, and it is followed by at least one cycle with `out_valid` at 0.
- R8: IA, IB and K are captured when a block starts. Changes to `cfg_ia`, `cfg_ib` and `cfg_slices` while the block runs have no effect on it.
- R9: A configuration value of 0 is used as 1, and a value above its build-time maximum is used as that maximum.
- R10: Each side has NUM_BANKS banks, which are written and read in round-robin order. A side's fill ready is 0 while its write bank is still closed and has not been replayed. A bank is released, and becomes writable again, at the final cycle of its block.
- R11: While `out_valid` is 0, both `out_first` and `out_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ia | input | IA_W | Requested A interleave factor |
| cfg_ib | input | IB_W | Requested B interleave factor |
| cfg_slices | input | KS_W | Requested slices per block |
| a_fill_valid | input | 1 | A fill beat present |
| a_fill_ready | output | 1 | A write bank can accept |
| a_fill_data | input | DATA_W | A operand vector |
| a_fill_last | input | 1 | Final beat of the A bank |
| b_fill_valid | input | 1 | B fill beat present |
| b_fill_ready | output | 1 | B write bank can accept |
| b_fill_data | input | DATA_W | B operand vector |
| b_fill_last | input | 1 | Final beat of the B bank |
| out_valid | output | 1 | Vector pair valid this cycle |
| out_a | output | DATA_W | A vector toward the array |
| out_b | output | DATA_W | B vector toward the array |
| out_slot | output | SLOT_W | Partial-sum slot index |
| out_first | output | 1 | Output belongs to slice 0 |
| out_last | output | 1 | Final output of the block |

## Verification
The bench builds the block with two banks, an A maximum of 4, an asymmetric B maximum of 3 and up to 4 slices. This makes the slot index non-square, and the 3-bit A and slice fields can carry values above their maxima, so clamping can be exercised. The longest block runs 48 cycles while the next bank is already closed, which makes the back-pressured fill state observable. Blocks of a single cycle bring the back-to-back bank rotation within reach. The factor inputs are scrambled during every block.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Index width able to address n distinct values, never below one bit.
    function automatic int unsigned idx_bits(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Map a requested factor into the legal range 1..cap.
    function automatic int unsigned clamp_factor(int unsigned raw, int unsigned cap);
        if (raw == 0) begin
            return 1;
        end
        if (raw > cap) begin
            return cap;
        end
        return raw;
    endfunction

endpackage

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
    parameter int NBANK = 2,
    parameter int DEPTH = 16,
    localparam int BK_W = ilv_pkg::idx_bits(NBANK),
    localparam int AW   = ilv_pkg::idx_bits(DEPTH),
    localparam int WA_W = ilv_pkg::idx_bits(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_valid,
    input  logic            fill_last,
    input  logic            release_i,
    output logic            fill_ready,
    output logic            wr_en,
    output logic [BK_W-1:0] wr_bank,
    output logic [AW-1:0]   wr_addr,
    output logic [BK_W-1:0] rd_bank,
    output logic            rd_full
);

    typedef struct packed {
        logic [NBANK-1:0] full;
        logic [BK_W-1:0]  wr_bank;
        logic [BK_W-1:0]  rd_bank;
        logic [WA_W-1:0]  wr_addr;
    } bank_state_t;

    bank_state_t q, d;
    logic        accept;

    always_comb begin
        d          = q;
        fill_ready = ~q.full[q.wr_bank];
        accept     = fill_valid & fill_ready;
        wr_en      = accept & (q.wr_addr < WA_W'(DEPTH));

        if (accept) begin
            if (fill_last) begin
                d.full[q.wr_bank] = 1'b1;
                d.wr_bank         = (q.wr_bank == BK_W'(NBANK - 1)) ? '0 : q.wr_bank + 1'b1;
                d.wr_addr         = '0;
            end else if (q.wr_addr < WA_W'(DEPTH)) begin
                d.wr_addr = q.wr_addr + 1'b1;
            end
        end

        if (release_i) begin
            d.full[q.rd_bank] = 1'b0;
            d.rd_bank         = (q.rd_bank == BK_W'(NBANK - 1)) ? '0 : q.rd_bank + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_bank = q.wr_bank;
    assign wr_addr = q.wr_addr[AW-1:0];
    assign rd_bank = q.rd_bank;
    assign rd_full = q.full[q.rd_bank];

endmodule

// File: rtl/ilv_bank_mem.sv
module ilv_bank_mem #(
    parameter int DATA_W = 16,
    parameter int NBANK  = 2,
    parameter int DEPTH  = 16,
    localparam int BK_W = ilv_pkg::idx_bits(NBANK),
    localparam int AW   = ilv_pkg::idx_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BK_W-1:0]   wr_bank,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BK_W-1:0]   rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] bank_out [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [DATA_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BK_W'(g))) begin
                cells[wr_addr] <= wr_data;
            end
        end

        assign bank_out[g] = cells[rd_addr];
    end

    assign rd_data = bank_out[rd_bank];

endmodule

// File: rtl/ilv_replay_seq.sv
module ilv_replay_seq #(
    parameter int DATA_W     = 16,
    parameter int MAX_IA     = 4,
    parameter int MAX_IB     = 4,
    parameter int MAX_SLICES = 4,
    localparam int IA_W   = ilv_pkg::idx_bits(MAX_IA + 1),
    localparam int IB_W   = ilv_pkg::idx_bits(MAX_IB + 1),
    localparam int KS_W   = ilv_pkg::idx_bits(MAX_SLICES + 1),
    localparam int A_AW   = ilv_pkg::idx_bits(MAX_IA * MAX_SLICES),
    localparam int B_AW   = ilv_pkg::idx_bits(MAX_IB * MAX_SLICES),
    localparam int SLOT_W = ilv_pkg::idx_bits(MAX_IA * MAX_IB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IA_W-1:0]   cfg_ia,
    input  logic [IB_W-1:0]   cfg_ib,
    input  logic [KS_W-1:0]   cfg_slices,
    input  logic              a_ready_bank,
    input  logic              b_ready_bank,
    input  logic [DATA_W-1:0] a_rd_data,
    input  logic [DATA_W-1:0] b_rd_data,
    output logic [A_AW-1:0]   a_rd_addr,
    output logic [B_AW-1:0]   b_rd_addr,
    output logic              release_o,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic [SLOT_W-1:0] out_slot,
    output logic              out_first,
    output logic              out_last
);

    typedef struct packed {
        logic              run;
        logic [IA_W-1:0]   ia;
        logic [IB_W-1:0]   ib;
        logic [KS_W-1:0]   ks;
        logic [IA_W-1:0]   ca;
        logic [IB_W-1:0]   cb;
        logic [KS_W-1:0]   cs;
        logic              o_valid;
        logic              o_first;
        logic              o_last;
        logic [SLOT_W-1:0] o_slot;
        logic [DATA_W-1:0] o_a;
        logic [DATA_W-1:0] o_b;
    } seq_state_t;

    seq_state_t q, d;
    logic end_a, end_b, end_s;

    always_comb begin
        d         = q;
        release_o = 1'b0;
        end_a     = (q.ca == q.ia - 1'b1);
        end_b     = (q.cb == q.ib - 1'b1);
        end_s     = (q.cs == q.ks - 1'b1);
        a_rd_addr = A_AW'(int'(q.cs) * int'(q.ia) + int'(q.ca));
        b_rd_addr = B_AW'(int'(q.cs) * int'(q.ib) + int'(q.cb));

        d.o_valid = 1'b0;
        d.o_first = 1'b0;
        d.o_last  = 1'b0;

        if (q.run) begin
            d.o_valid = 1'b1;
            d.o_first = (q.cs == '0);
            d.o_last  = end_a & end_b & end_s;
            d.o_slot  = SLOT_W'(int'(q.cb) * int'(q.ia) + int'(q.ca));
            d.o_a     = a_rd_data;
            d.o_b     = b_rd_data;

            if (!end_a) begin
                d.ca = q.ca + 1'b1;
            end else begin
                d.ca = '0;
                if (!end_b) begin
                    d.cb = q.cb + 1'b1;
                end else begin
                    d.cb = '0;
                    if (!end_s) begin
                        d.cs = q.cs + 1'b1;
                    end else begin
                        d.cs      = '0;
                        d.run     = 1'b0;
                        release_o = 1'b1;
                    end
                end
            end
        end else if (a_ready_bank && b_ready_bank) begin
            d.run = 1'b1;
            d.ia  = IA_W'(ilv_pkg::clamp_factor(32'(cfg_ia), MAX_IA));
            d.ib  = IB_W'(ilv_pkg::clamp_factor(32'(cfg_ib), MAX_IB));
            d.ks  = KS_W'(ilv_pkg::clamp_factor(32'(cfg_slices), MAX_SLICES));
            d.ca  = '0;
            d.cb  = '0;
            d.cs  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.o_valid;
    assign out_a     = q.o_a;
    assign out_b     = q.o_b;
    assign out_slot  = q.o_slot;
    assign out_first = q.o_first;
    assign out_last  = q.o_last;

endmodule

// File: rtl/ilv_operand_feeder.sv
module ilv_operand_feeder #(
    parameter int DATA_W     = 16,
    parameter int NUM_BANKS  = 2,
    parameter int MAX_IA     = 4,
    parameter int MAX_IB     = 4,
    parameter int MAX_SLICES = 4,
    localparam int IA_W    = ilv_pkg::idx_bits(MAX_IA + 1),
    localparam int IB_W    = ilv_pkg::idx_bits(MAX_IB + 1),
    localparam int KS_W    = ilv_pkg::idx_bits(MAX_SLICES + 1),
    localparam int SLOT_W  = ilv_pkg::idx_bits(MAX_IA * MAX_IB),
    localparam int A_DEPTH = MAX_IA * MAX_SLICES,
    localparam int B_DEPTH = MAX_IB * MAX_SLICES,
    localparam int A_AW    = ilv_pkg::idx_bits(A_DEPTH),
    localparam int B_AW    = ilv_pkg::idx_bits(B_DEPTH),
    localparam int BK_W    = ilv_pkg::idx_bits(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IA_W-1:0]   cfg_ia,
    input  logic [IB_W-1:0]   cfg_ib,
    input  logic [KS_W-1:0]   cfg_slices,
    input  logic              a_fill_valid,
    output logic              a_fill_ready,
    input  logic [DATA_W-1:0] a_fill_data,
    input  logic              a_fill_last,
    input  logic              b_fill_valid,
    output logic              b_fill_ready,
    input  logic [DATA_W-1:0] b_fill_data,
    input  logic              b_fill_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic [SLOT_W-1:0] out_slot,
    output logic              out_first,
    output logic              out_last
);

    logic              blk_release;
    logic              a_wr_en, b_wr_en;
    logic [BK_W-1:0]   a_wr_bank, b_wr_bank, a_rd_bank, b_rd_bank;
    logic [A_AW-1:0]   a_wr_addr, a_rd_addr;
    logic [B_AW-1:0]   b_wr_addr, b_rd_addr;
    logic              a_full, b_full;
    logic [DATA_W-1:0] a_rd_data, b_rd_data;

    ilv_bank_ctrl #(.NBANK(NUM_BANKS), .DEPTH(A_DEPTH)) u_a_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(a_fill_valid), .fill_last(a_fill_last), .release_i(blk_release),
        .fill_ready(a_fill_ready), .wr_en(a_wr_en), .wr_bank(a_wr_bank),
        .wr_addr(a_wr_addr), .rd_bank(a_rd_bank), .rd_full(a_full)
    );

    ilv_bank_ctrl #(.NBANK(NUM_BANKS), .DEPTH(B_DEPTH)) u_b_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(b_fill_valid), .fill_last(b_fill_last), .release_i(blk_release),
        .fill_ready(b_fill_ready), .wr_en(b_wr_en), .wr_bank(b_wr_bank),
        .wr_addr(b_wr_addr), .rd_bank(b_rd_bank), .rd_full(b_full)
    );

    ilv_bank_mem #(.DATA_W(DATA_W), .NBANK(NUM_BANKS), .DEPTH(A_DEPTH)) u_a_mem (
        .clk(clk), .wr_en(a_wr_en), .wr_bank(a_wr_bank), .wr_addr(a_wr_addr),
        .wr_data(a_fill_data), .rd_bank(a_rd_bank), .rd_addr(a_rd_addr), .rd_data(a_rd_data)
    );

    ilv_bank_mem #(.DATA_W(DATA_W), .NBANK(NUM_BANKS), .DEPTH(B_DEPTH)) u_b_mem (
        .clk(clk), .wr_en(b_wr_en), .wr_bank(b_wr_bank), .wr_addr(b_wr_addr),
        .wr_data(b_fill_data), .rd_bank(b_rd_bank), .rd_addr(b_rd_addr), .rd_data(b_rd_data)
    );

    ilv_replay_seq #(
        .DATA_W(DATA_W), .MAX_IA(MAX_IA), .MAX_IB(MAX_IB), .MAX_SLICES(MAX_SLICES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_ia(cfg_ia), .cfg_ib(cfg_ib), .cfg_slices(cfg_slices),
        .a_ready_bank(a_full), .b_ready_bank(b_full),
        .a_rd_data(a_rd_data), .b_rd_data(b_rd_data),
        .a_rd_addr(a_rd_addr), .b_rd_addr(b_rd_addr),
        .release_o(blk_release),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_slot(out_slot),
        .out_first(out_first), .out_last(out_last)
    );

endmodule

// File: rtl/ilv_feeder_checks.sv
module ilv_feeder_checks #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_fill_valid,
    input logic              a_fill_ready,
    input logic              a_fill_last,
    input logic              b_fill_valid,
    input logic              b_fill_ready,
    input logic              b_fill_last,
    input logic              out_valid,
    input logic [SLOT_W-1:0] out_slot,
    input logic              out_first,
    input logic              out_last
);

    // R7: the final output of a block is followed by an idle cycle
    a_r7_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    // R5: inside a slice the slot index climbs by one
    a_r5_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(out_last) && (out_slot != '0))
        |-> (out_slot == SLOT_W'($past(out_slot) + 1'b1)));

    // R6: a block opens with slot 0 of the first slice
    a_r6_block_opens_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> (out_first && (out_slot == '0)));

    // R6: once slice 0 is over, the first flag stays low for the rest of the block
    a_r6_first_not_reentered: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(out_first)) |-> !out_first);

    // R11: flags are quiet while nothing is valid
    a_r11_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_first && !out_last));

    // R10: a side only stops accepting after it closed a bank
    a_r10_a_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_fill_ready) |-> $past(a_fill_valid && a_fill_last));

    a_r10_b_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_fill_ready) |-> $past(b_fill_valid && b_fill_last));

endmodule

bind ilv_operand_feeder ilv_feeder_checks #(.SLOT_W(SLOT_W)) u_feeder_checks (
    .clk(clk), .rst_n(rst_n),
    .a_fill_valid(a_fill_valid), .a_fill_ready(a_fill_ready), .a_fill_last(a_fill_last),
    .b_fill_valid(b_fill_valid), .b_fill_ready(b_fill_ready), .b_fill_last(b_fill_last),
    .out_valid(out_valid), .out_slot(out_slot), .out_first(out_first), .out_last(out_last)
);

// File: tb/tb_ilv_operand_feeder.sv
module tb_ilv_operand_feeder;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DATA_W = 16;
    localparam int NB     = 2;
    localparam int MAX_IA = 4;
    localparam int MAX_IB = 3;
    localparam int MAX_KS = 4;
    localparam int IA_W   = 3;
    localparam int IB_W   = 2;
    localparam int KS_W   = 3;
    localparam int SLOT_W = 4;
    localparam int NBLK   = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IA_W-1:0]   cfg_ia = '0;
    logic [IB_W-1:0]   cfg_ib = '0;
    logic [KS_W-1:0]   cfg_slices = '0;
    logic              a_fill_valid = 1'b0, a_fill_last = 1'b0;
    logic              b_fill_valid = 1'b0, b_fill_last = 1'b0;
    logic [DATA_W-1:0] a_fill_data = '0, b_fill_data = '0;
    logic              a_fill_ready, b_fill_ready;
    logic              out_valid, out_first, out_last;
    logic [DATA_W-1:0] out_a, out_b;
    logic [SLOT_W-1:0] out_slot;

    always #5 clk = ~clk;

    ilv_operand_feeder #(
        .DATA_W(DATA_W), .NUM_BANKS(NB), .MAX_IA(MAX_IA), .MAX_IB(MAX_IB), .MAX_SLICES(MAX_KS)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ia(cfg_ia), .cfg_ib(cfg_ib), .cfg_slices(cfg_slices),
        .a_fill_valid(a_fill_valid), .a_fill_ready(a_fill_ready),
        .a_fill_data(a_fill_data), .a_fill_last(a_fill_last),
        .b_fill_valid(b_fill_valid), .b_fill_ready(b_fill_ready),
        .b_fill_data(b_fill_data), .b_fill_last(b_fill_last),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_slot(out_slot),
        .out_first(out_first), .out_last(out_last)
    );

    int errors = 0;
    int checks = 0;
    int exp_a [NBLK][MAX_IA*MAX_KS];
    int exp_b [NBLK][MAX_IB*MAX_KS];
    int e_ia [NBLK];
    int e_ib [NBLK];
    int e_ks [NBLK];
    int mon_started = 0, mon_done = 0;
    int mb = 0, ms = 0, mbb = 0, ma = 0, vcount = 0;
    bit finished = 1'b0;

    function automatic int clampf(int raw, int cap);
        if (raw == 0) return 1;
        if (raw > cap) return cap;
        return raw;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Output monitor: compares every cycle against the nested replay model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (mb >= NBLK) begin
                    chk(1'b0, "R7 output beyond last block", 1, 0);
                end else begin
                    int ia, ib, ks, ea, eb, eslot;
                    bit elast;
                    ia = e_ia[mb]; ib = e_ib[mb]; ks = e_ks[mb];
                    ea = exp_a[mb][ms*ia + ma];
                    eb = exp_b[mb][ms*ib + mbb];
                    eslot = mbb*ia + ma;
                    elast = (ma == ia-1) && (mbb == ib-1) && (ms == ks-1);
                    if (ms == 0 && mbb == 0 && ma == 0) mon_started++;
                    chk(int'(out_a) == ea, "R2 R4 R8 A vector", int'(out_a), ea);
                    chk(int'(out_b) == eb, "R2 R4 R8 B vector", int'(out_b), eb);
                    chk(int'(out_slot) == eslot, "R5 slot index", int'(out_slot), eslot);
                    chk(out_first == (ms == 0), "R6 first flag", int'(out_first), int'(ms == 0));
                    chk(out_last == elast, "R7 last flag", int'(out_last), int'(elast));
                    vcount++;
                    if (elast) begin
                        chk(vcount == ia*ib*ks, "R7 R9 block length", vcount, ia*ib*ks);
                        mon_done++;
                        mb++;
                        ms = 0; mbb = 0; ma = 0; vcount = 0;
                    end else if (ma != ia-1) begin
                        ma++;
                    end else begin
                        ma = 0;
                        if (mbb != ib-1) mbb++;
                        else begin mbb = 0; ms++; end
                    end
                end
            end else begin
                chk(!out_first && !out_last, "R11 flags while idle",
                    int'({out_first, out_last}), 0);
            end
        end
    end

    task automatic prep(int n, int ria, int rib, int rks);
        e_ia[n] = clampf(ria, MAX_IA);
        e_ib[n] = clampf(rib, MAX_IB);
        e_ks[n] = clampf(rks, MAX_KS);
        for (int i = 0; i < MAX_IA*MAX_KS; i++) exp_a[n][i] = int'($urandom & 32'hFFFF);
        for (int i = 0; i < MAX_IB*MAX_KS; i++) exp_b[n][i] = int'($urandom & 32'hFFFF);
        cfg_ia     = IA_W'(ria);
        cfg_ib     = IB_W'(rib);
        cfg_slices = KS_W'(rks);
    endtask

    task automatic fill_a(int n);
        int cnt;
        cnt = e_ia[n] * e_ks[n];
        for (int i = 0; i < cnt; i++) begin
            bit acc;
            a_fill_valid = 1'b1;
            a_fill_data  = DATA_W'(exp_a[n][i]);
            a_fill_last  = (i == cnt-1);
            do begin
                @(negedge clk); acc = a_fill_ready;
                @(posedge clk); #1;
            end while (!acc);
        end
        a_fill_valid = 1'b0;
        a_fill_last  = 1'b0;
    endtask

    task automatic fill_b(int n);
        int cnt;
        cnt = e_ib[n] * e_ks[n];
        for (int i = 0; i < cnt; i++) begin
            bit acc;
            b_fill_valid = 1'b1;
            b_fill_data  = DATA_W'(exp_b[n][i]);
            b_fill_last  = (i == cnt-1);
            do begin
                @(negedge clk); acc = b_fill_ready;
                @(posedge clk); #1;
            end while (!acc);
        end
        b_fill_valid = 1'b0;
        b_fill_last  = 1'b0;
    endtask

    task automatic prep_block(int n);
        case (n)
            0: prep(n, 4, 3, 4);   // longest block
            1: prep(n, 1, 1, 1);   // single cycle
            2: prep(n, 0, 0, 0);   // zero requests clamp to one (R9)
            3: prep(n, 7, 3, 6);   // above maximum clamps (R9)
            4: prep(n, 2, 3, 1);
            default: prep(n, int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                          int'($urandom_range(0, 7)));
        endcase
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_first && !out_last, "R1 outputs after reset", int'(out_valid), 0);
        chk(a_fill_ready && b_fill_ready, "R1 fill ready after reset",
            int'({a_fill_ready, b_fill_ready}), 3);
        @(posedge clk); #1;

        prep_block(0);
        fill_a(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R3 no start with only the A bank closed", int'(out_valid), 0);
        @(posedge clk); #1;
        fill_b(0);

        for (int n = 0; n < NBLK; n++) begin
            while (mon_started <= n) @(negedge clk);
            @(posedge clk); #1;
            // scramble the factor inputs while block n runs (R8)
            for (int j = 0; j < 3; j++) begin
                cfg_ia     = IA_W'($urandom);
                cfg_ib     = IB_W'($urandom);
                cfg_slices = KS_W'($urandom);
                @(posedge clk); #1;
            end
            if (n + 1 < NBLK) begin
                prep_block(n + 1);
                fork
                    fill_a(n + 1);
                    fill_b(n + 1);
                join
            end
            if (n == 0) begin
                @(negedge clk);
                chk(!a_fill_ready && !b_fill_ready, "R10 ready low with all banks closed",
                    int'({a_fill_ready, b_fill_ready}), 0);
                do @(negedge clk); while (!(out_valid && out_last));
                chk(a_fill_ready && b_fill_ready, "R10 ready back after release",
                    int'({a_fill_ready, b_fill_ready}), 3);
                @(posedge clk); #1;
            end
        end

        while (mon_done < NBLK) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1'b1;
        chk(mb == NBLK, "R7 all blocks completed", mb, NBLK);
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        finished = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog R7 blocks done=%0d expected=%0d", mon_done, NBLK);
        report();
        $finish;
    end

endmodule